// File: doc/BRIEF.md
# Clock Policy Mask Register Block

This block holds the per-policy clock enable masks of a clock control unit. Each power policy has one mask word, and bit n of every word controls clock n. A two-bit current-policy input picks which word drives the clock enable vector. The vector is registered once per cycle.

Software reaches the block through a simple word-addressed register bus, with a write strobe, an address and write data, and combinational read data. Three conditions guard mask changes:

- Writes are refused until a password has been written to the key register at word 0.
- A mask edit is dropped unless the policy engine has first been halted. A dropped edit sets a sticky error flag.
- The engine resumes only on a restart command that carries exactly one of two restart modes.

Top module: `clkpol_regs`

## Requirements
- R1: After reset all mask words read all ones, the block is locked, the engine is running, the error flag, busy bit and latched mode are zero, and `clk_en` is zero while reset is held.
- R2: Writing the key value to word 0 unlocks the block. Writing any other value to word 0 locks it. Word 0 reads the unlocked state in bit 0.
- R3: While locked, a write to any word other than 0 changes nothing (halt, restart, error clear and masks).
- R4: Mask words sit at word addresses 4 to 7, one per policy, NUM_CLK bits wide. A write to one takes effect only when the block is unlocked and the engine is halted. Otherwise the write is dropped.
- R5: A dropped mask write sets the sticky error flag, which reads in bit 0 of word 3.
- R6: Writing 1 to bit 0 of word 1 while unlocked halts the engine. Word 1 bit 0 reads the halted state. Writing 0 there has no effect.
- R7: In word 2, bit 0 is the restart command, bit 1 selects the hold mode and bit 2 the auto mode. A write with bit 0 set and exactly one mode bit is accepted. On acceptance the halt is cleared, the mode is latched into read bits 2:1, and read bit 0 (busy) is 1 for exactly one cycle.
- R8: A restart write with neither or both mode bits set is ignored: the halt state, the busy bit and the latched mode stay as they were.
- R9: `clk_en` equals the mask word selected by `pol_sel`, one clock edge after the word or the selection changes.
- R10: Writing 1 to bit 0 of word 3 while unlocked clears the error flag. Writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| pol_sel | input | POL_W | Current policy index |
| clk_en | output | NUM_CLK | Registered per-clock enable vector |

## Verification
The hardest state to reach is an accepted mask edit. It needs two earlier register writes in the right order, and either one can be undone silently by a lock or a restart. The stimulus table therefore chains its writes. It first shows an edit being dropped while the engine runs, then unlocks and halts the engine, and then edits. After that it restarts the engine and shows that later edits are dropped again. A final series re-locks the block and confirms that halt, restart and error-clear writes are all refused. The registered enable path is then checked edge by edge against both mask edits and policy switches.

// File: rtl/clkpol_pkg.sv
package clkpol_pkg;
   // word addresses of the control registers
   localparam int unsigned REG_KEY  = 0;
   localparam int unsigned REG_HALT = 1;
   localparam int unsigned REG_GO   = 2;
   localparam int unsigned REG_STAT = 3;

   // bit positions in the restart register
   localparam int unsigned GO_BIT   = 0;
   localparam int unsigned HOLD_BIT = 1;
   localparam int unsigned AUTO_BIT = 2;

   typedef enum logic [1:0] {
      MODE_NONE = 2'b00,
      MODE_HOLD = 2'b01,
      MODE_AUTO = 2'b10
   } restart_mode_e;
endpackage

// File: rtl/clkpol_access.sv
module clkpol_access #(
   parameter int unsigned          DATA_W = 32,
   parameter int unsigned          ADDR_W = 4,
   parameter logic [DATA_W-1:0]    KEY    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              unlocked
);
   import clkpol_pkg::*;

   logic key_hit;
   assign key_hit = wr && (addr == ADDR_W'(REG_KEY));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       unlocked <= 1'b0;
      else if (key_hit) unlocked <= (wdata == KEY);
   end

   a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit && (wdata == KEY) |=> unlocked);
   a_r2_other_relocks: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit && (wdata != KEY) |=> !unlocked);
endmodule

// File: rtl/clkpol_engine.sv
module clkpol_engine #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              unlocked,
   output logic              halted,
   output logic              go_busy,
   output clkpol_pkg::restart_mode_e mode
);
   import clkpol_pkg::*;

   logic halt_wr, go_wr, go_ok;
   assign halt_wr = wr && unlocked && (addr == ADDR_W'(REG_HALT)) && wdata[0];
   assign go_wr   = wr && unlocked && (addr == ADDR_W'(REG_GO)) && wdata[GO_BIT];
   assign go_ok   = go_wr && (wdata[HOLD_BIT] ^ wdata[AUTO_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted  <= 1'b0;
         go_busy <= 1'b0;
         mode    <= MODE_NONE;
      end else begin
         go_busy <= go_ok;
         if (go_ok) begin
            halted <= 1'b0;
            mode   <= wdata[HOLD_BIT] ? MODE_HOLD : MODE_AUTO;
         end else if (halt_wr) begin
            halted <= 1'b1;
         end
      end
   end

   a_r3_locked_halt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      wr && !unlocked && (addr == ADDR_W'(REG_HALT)) |=> halted == $past(halted));
   a_r7_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      go_busy |=> !go_busy);
   a_r7_busy_means_running: assert property (@(posedge clk) disable iff (!rst_n)
      go_busy |-> !halted);
   a_r8_bad_mode_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      wr && (addr == ADDR_W'(REG_GO)) && (wdata[HOLD_BIT] == wdata[AUTO_BIT])
      |=> !go_busy && (halted == $past(halted)) && (mode == $past(mode)));
endmodule

// File: rtl/clkpol_masks.sv
module clkpol_masks #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned NUM_POL   = 4,
   parameter int unsigned NUM_CLK   = 32,
   parameter int unsigned MASK_BASE = 4,
   parameter bit          RESET_ON  = 1'b1,
   parameter bit          REG_OUT   = 1'b1,
   localparam int unsigned POL_W    = (NUM_POL > 1) ? $clog2(NUM_POL) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [DATA_W-1:0]                wdata,
   input  logic                             unlocked,
   input  logic                             halted,
   input  logic [POL_W-1:0]                 pol_sel,
   output logic [NUM_POL-1:0][NUM_CLK-1:0]  masks,
   output logic                             err,
   output logic [NUM_CLK-1:0]               clk_en
);
   import clkpol_pkg::*;

   localparam logic [NUM_CLK-1:0] MASK_RST = RESET_ON ? '1 : '0;

   logic mask_hit, edit_ok, err_clr;
   logic [NUM_CLK-1:0] sel_word;

   assign mask_hit = wr && (addr >= ADDR_W'(MASK_BASE)) &&
                     (addr <  ADDR_W'(MASK_BASE + NUM_POL));
   assign edit_ok  = unlocked && halted;
   assign err_clr  = wr && unlocked && (addr == ADDR_W'(REG_STAT)) && wdata[0];

   for (genvar p = 0; p < NUM_POL; p++) begin : g_pol
      logic hit_p;
      assign hit_p = wr && (addr == ADDR_W'(MASK_BASE + p));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                masks[p] <= MASK_RST;
         else if (hit_p && edit_ok) masks[p] <= wdata[NUM_CLK-1:0];
      end

      a_r4_drop_when_guarded: assert property (@(posedge clk) disable iff (!rst_n)
         hit_p && !edit_ok |=> $stable(masks[p]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    err <= 1'b0;
      else if (mask_hit && !edit_ok) err <= 1'b1;
      else if (err_clr)              err <= 1'b0;
   end

   if (NUM_POL == (1 << POL_W)) begin : g_sel_full
      assign sel_word = masks[pol_sel];
   end else begin : g_sel_guard
      always_comb begin
         sel_word = '0;
         for (int i = 0; i < NUM_POL; i++)
            if (pol_sel == POL_W'(i)) sel_word = masks[i];
      end
   end

   if (REG_OUT) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) clk_en <= '0;
         else        clk_en <= sel_word;
      end
   end else begin : g_out_comb
      assign clk_en = sel_word;
   end

   a_r5_err_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
      mask_hit && !edit_ok |=> err);
   a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err && !err_clr |=> err);
   a_r10_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr && !mask_hit |=> !err);
endmodule

// File: rtl/clkpol_regs.sv
module clkpol_regs #(
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       ADDR_W    = 4,
   parameter int unsigned       NUM_POL   = 4,
   parameter int unsigned       NUM_CLK   = 32,
   parameter int unsigned       MASK_BASE = 4,
   parameter logic [DATA_W-1:0] KEY       = DATA_W'(32'h5AC3_0F96),
   parameter bit                RESET_ON  = 1'b1,
   parameter bit                REG_OUT   = 1'b1,
   localparam int unsigned      POL_W     = (NUM_POL > 1) ? $clog2(NUM_POL) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [POL_W-1:0]   pol_sel,
   output logic [NUM_CLK-1:0] clk_en
);
   import clkpol_pkg::*;

   initial begin : p_param_chk
      assert (NUM_CLK >= 1 && NUM_CLK <= DATA_W)
         else $error("NUM_CLK must fit in one data word");
      assert (MASK_BASE > REG_STAT)
         else $error("mask words overlap control registers");
      assert (MASK_BASE + NUM_POL <= (1 << ADDR_W))
         else $error("mask words exceed address space");
      assert (DATA_W >= 3)
         else $error("data word too narrow for restart fields");
   end

   logic                            unlocked, halted, go_busy, err;
   restart_mode_e                   mode;
   logic [NUM_POL-1:0][NUM_CLK-1:0] masks;

   clkpol_access #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY(KEY)) u_access (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .unlocked(unlocked));

   clkpol_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .unlocked(unlocked), .halted(halted),
      .go_busy(go_busy), .mode(mode));

   clkpol_masks #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_POL(NUM_POL),
      .NUM_CLK(NUM_CLK), .MASK_BASE(MASK_BASE), .RESET_ON(RESET_ON),
      .REG_OUT(REG_OUT)) u_masks (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .unlocked(unlocked), .halted(halted),
      .pol_sel(pol_sel), .masks(masks), .err(err), .clk_en(clk_en));

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(REG_KEY):  bus_rdata[0] = unlocked;
         ADDR_W'(REG_HALT): bus_rdata[0] = halted;
         ADDR_W'(REG_GO):   bus_rdata[2:0] = {mode, go_busy};
         ADDR_W'(REG_STAT): bus_rdata[0] = err;
         default: begin
            for (int i = 0; i < NUM_POL; i++)
               if (bus_addr == ADDR_W'(MASK_BASE + i))
                  bus_rdata = DATA_W'(masks[i]);
         end
      endcase
   end

   a_r3_locked_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !unlocked && (bus_addr == ADDR_W'(REG_GO)) |=> !go_busy);
   a_r3_locked_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !unlocked && err |=> err);
endmodule

// File: tb/clkpol_regs_bench.sv
module clkpol_regs_bench;
   localparam logic [31:0] KEY = 32'h5AC3_0F96;
   localparam int NV = 19;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  pol_sel = '0;
   logic [31:0] clk_en;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   clkpol_regs u_clkpol_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pol_sel(pol_sel),
      .clk_en(clk_en));

   // {write addr, write data, read addr, expected read}
   localparam logic [71:0] VEC [NV] = '{
      {4'd0, KEY,            4'd0, 32'h1},          // R2 unlock
      {4'd4, 32'h0000_00FF,  4'd4, 32'hFFFF_FFFF},  // R4 running: dropped
      {4'd0, KEY,            4'd3, 32'h1},          // R5 error set
      {4'd3, 32'h0,          4'd3, 32'h1},          // R10 write 0 keeps it
      {4'd1, 32'h1,          4'd1, 32'h1},          // R6 halt
      {4'd1, 32'h0,          4'd1, 32'h1},          // R6 write 0 no effect
      {4'd4, 32'h0000_00FF,  4'd4, 32'h0000_00FF},  // R4 edit accepted
      {4'd5, 32'h1234_5678,  4'd5, 32'h1234_5678},  // R4
      {4'd3, 32'h1,          4'd3, 32'h0},          // R10 clear
      {4'd2, 32'h7,          4'd1, 32'h1},          // R8 both modes
      {4'd2, 32'h1,          4'd2, 32'h0},          // R8 no mode
      {4'd2, 32'h3,          4'd2, 32'h3},          // R7 go hold, busy
      {4'd6, 32'h0000_AAAA,  4'd1, 32'h0},          // R7 halt cleared
      {4'd0, KEY,            4'd6, 32'hFFFF_FFFF},  // R4 dropped after go
      {4'd0, KEY,            4'd2, 32'h2},          // R7 busy gone, mode held
      {4'd0, 32'h0,          4'd0, 32'h0},          // R2 relock
      {4'd1, 32'h1,          4'd1, 32'h0},          // R3 halt refused
      {4'd3, 32'h1,          4'd3, 32'h1},          // R3 clear refused
      {4'd2, 32'h5,          4'd2, 32'h2}           // R3 go refused
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic read_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1 check(req, bus_rdata, exp);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(posedge clk);
      #1 check("R1 en in reset", clk_en, 32'h0);
      read_chk("R1 key", 4'd0, 32'h0);
      read_chk("R1 halt", 4'd1, 32'h0);
      read_chk("R1 go", 4'd2, 32'h0);
      read_chk("R1 err", 4'd3, 32'h0);
      for (int i = 4; i < 8; i++) read_chk("R1 mask", 4'(i), 32'hFFFF_FFFF);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1 check("R9 en after reset", clk_en, 32'hFFFF_FFFF);

      for (int i = 0; i < NV; i++) begin
         bus_write(VEC[i][71:68], VEC[i][67:36]);
         read_chk($sformatf("vec %0d", i), VEC[i][35:32], VEC[i][31:0]);
      end

      // R9 enable output timing
      bus_write(4'd0, KEY);
      bus_write(4'd1, 32'h1);
      @(negedge clk) pol_sel = 2'd3;
      @(posedge clk); #1 check("R9 sel 3", clk_en, 32'hFFFF_FFFF);
      bus_write(4'd7, 32'h0F0F_0F0F);
      check("R9 not yet", clk_en, 32'hFFFF_FFFF);
      @(posedge clk); #1 check("R9 mask edit", clk_en, 32'h0F0F_0F0F);
      @(negedge clk) pol_sel = 2'd0;
      @(posedge clk); #1 check("R9 sel 0", clk_en, 32'h0000_00FF);
      @(negedge clk) pol_sel = 2'd1;
      @(posedge clk); #1 check("R9 sel 1", clk_en, 32'h1234_5678);

      // R7 auto mode restart
      bus_write(4'd2, 32'h5);
      read_chk("R7 auto busy", 4'd2, 32'h5);
      @(posedge clk);
      read_chk("R7 auto settled", 4'd2, 32'h4);
      read_chk("R7 running", 4'd1, 32'h0);

      done = 1'b1;
      finish_run();
   end
endmodule